// File: doc/BRIEF.md
# Dual-Threshold Watchdog Timer

A 12-bit down-counting watchdog that software keeps alive by writing a keyed restart word. The counter decrements once for every `DIV` pulses of a slow-clock strobe. Three comparisons run against it. Reaching zero is a period expiry. A restart that comes while the count is still above a repeat threshold is an early restart. A decrement that lands on a level threshold is a level event. Each comparison sets its own interrupt status bit. Period expiry and early restart can each be routed to a one-cycle reset request by their own mode bit.

Interrupt handling uses a set/clear/read mask register set and a status register that clears when read. The interrupt output is the OR of all status bits that are enabled by the mask. Two further status bits mirror the period and early-restart events as plain flags. A mode register holds a disable bit and two freeze bits. The freeze bits stop counting while the debug-halt input or the idle input is high. All registers are reached through a simple word-addressed read/write port with a combinational read path.

Top module: `dual_thresh_wdog`

## Requirements
- R1: After reset, the value register (0x08) reads 0xFFF, the mode register (0x04) reads 0x00001000 (disabled), the mask (0x20) and the status (0x1C) read 0, and `irq` and `rst_req` are low.
- R2: When enabled and not frozen, the count drops by exactly one on every `DIV`th `slow_tick` pulse. A reload clears the prescaler, so the first decrement comes `DIV` pulses after the reload.
- R3: A control write (0x00) with 0xA5 in bits 31:24 and bit 0 set is a restart. When the count is at or below the repeat threshold (0x0C bits 27:16), the restart reloads the count from the period (0x0C bits 11:0), whether the timer is enabled or not. A write with any other key has no effect.
- R4: A decrement that brings the count to zero sets status bit 0 and bit 3. The next tick after that reloads the count from the period.
- R5: With mode bit 4 set, a period expiry drives `rst_req` high for exactly one cycle, starting on the same edge that sets the status bit.
- R6: A restart while the count is above the repeat threshold does not reload the count. It sets status bit 1 and bit 4, and it pulses `rst_req` for one cycle only if mode bit 5 is set.
- R7: A decrement that lands on the level threshold (0x10 bits 11:0) sets status bit 2.
- R8: While mode bit 12 is set, the count does not change except by a restart.
- R9: Mode bit 28 with `dbg_halt` high, or mode bit 29 with `idle` high, freezes the count. Either input alone, without its mode bit, does not freeze it.
- R10: Writing ones to 0x14 sets mask bits and writing ones to 0x18 clears them. 0x20 reads the mask, and `irq` is high exactly when some status bit and its mask bit are both set.
- R11: A read of the status register returns the current status and clears every bit that no event sets in that same cycle.
- R12: Writes to the value register are ignored, and reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe per slow-clock period, synchronous to clk |
| dbg_halt | input | 1 | Debug-halt indication |
| idle | input | 1 | Idle indication |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status on a status read) |
| addr | input | 6 | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | OR of status AND mask |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The properties assume at most one register access per cycle: `wr_en` and `rd_en` are never high together, and addresses are word aligned. They also assume that `slow_tick`, `dbg_halt` and `idle` are synchronous to `clk`. The stimulus changes every input only on the falling edge and issues accesses strictly one after another. It never overlaps a status read with a rising event unless that overlap is the point of the check. Exact-cycle checks begin right after a reload, because the reload clears the prescaler and so gives a known phase.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
  localparam int CNT_W  = 12;
  localparam int NIRQ   = 5;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam logic [7:0] RESTART_KEY = 8'hA5;

  // word index = byte address / 4
  localparam logic [3:0] IX_CTRL = 4'd0;
  localparam logic [3:0] IX_MODE = 4'd1;
  localparam logic [3:0] IX_VAL  = 4'd2;
  localparam logic [3:0] IX_WIN  = 4'd3;
  localparam logic [3:0] IX_LVL  = 4'd4;
  localparam logic [3:0] IX_IEN  = 4'd5;
  localparam logic [3:0] IX_IDIS = 4'd6;
  localparam logic [3:0] IX_STAT = 4'd7;
  localparam logic [3:0] IX_MASK = 4'd8;

  // interrupt bit positions
  localparam int IB_PER   = 0;
  localparam int IB_REP   = 1;
  localparam int IB_LVL   = 2;
  localparam int IB_PER_M = 3;
  localparam int IB_REP_M = 4;

  // mode bit positions
  localparam int MB_PRST = 4;
  localparam int MB_RRST = 5;
  localparam int MB_DIS  = 12;
  localparam int MB_DBG  = 28;
  localparam int MB_IDLE = 29;
endpackage

// File: rtl/dtw_prescale.sv
module dtw_prescale #(
  parameter int DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_tick,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int PSC_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PSC_W-1:0] LAST = PSC_W'(DIV - 1);

  logic [PSC_W-1:0] psc_q, psc_d;
  logic             step;

  assign step = run && slow_tick;
  assign tick = step && (psc_q == LAST);

  always_comb begin
    psc_d = psc_q;
    if (clear)     psc_d = '0;
    else if (tick) psc_d = '0;
    else if (step) psc_d = psc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psc_q <= '0;
    else        psc_q <= psc_d;
  end
endmodule

// File: rtl/dtw_core.sv
module dtw_core #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] rpth,
  input  logic [CNT_W-1:0] lvl,
  output logic [CNT_W-1:0] cnt,
  output logic             reload,
  output logic             rep_evt,
  output logic             per_evt,
  output logic             lvl_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, dec;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign dec     = cnt_q - ONE;
  assign reload  = restart && (cnt_q <= rpth);
  assign rep_evt = restart && (cnt_q > rpth);
  assign per_evt = tick && !reload && ((cnt_q == ONE) || (at_zero && period == '0));
  assign lvl_evt = tick && !reload && !at_zero && (dec == lvl);

  always_comb begin
    cnt_d = cnt_q;
    if (reload)    cnt_d = period;
    else if (tick) cnt_d = at_zero ? period : dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/dtw_irq.sv
module dtw_irq #(
  parameter int NIRQ = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] set_vec,
  input  logic            stat_rd,
  input  logic            ien_we,
  input  logic            idis_we,
  input  logic [NIRQ-1:0] wbits,
  output logic [NIRQ-1:0] status,
  output logic [NIRQ-1:0] mask,
  output logic            irq
);
  logic [NIRQ-1:0] stat_q, stat_d, mask_q, mask_d;

  always_comb begin
    stat_d = (stat_rd ? '0 : stat_q) | set_vec;
    mask_d = mask_q;
    if (ien_we)  mask_d = mask_q | wbits;
    if (idis_we) mask_d = mask_q & ~wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
    end
  end

  assign status = stat_q;
  assign mask   = mask_q;
  assign irq    = |(stat_q & mask_q);
endmodule

// File: rtl/dual_thresh_wdog.sv
module dual_thresh_wdog
  import dtw_pkg::*;
#(
  parameter int DIV = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              dbg_halt,
  input  logic              idle,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              rst_req
);
  logic [3:0] idx;
  assign idx = addr[ADDR_W-1:2];

  // configuration registers
  logic [CNT_W-1:0] period_q, period_d, rpth_q, rpth_d, lvl_q, lvl_d;
  logic m_prst_q, m_prst_d, m_rrst_q, m_rrst_d, m_dis_q, m_dis_d;
  logic m_dbg_q, m_dbg_d, m_idle_q, m_idle_d;
  logic rst_req_q, rst_req_d;

  logic mode_we, win_we, lvl_we, ien_we, idis_we, stat_rd, restart;
  assign mode_we = wr_en && (idx == IX_MODE);
  assign win_we  = wr_en && (idx == IX_WIN);
  assign lvl_we  = wr_en && (idx == IX_LVL);
  assign ien_we  = wr_en && (idx == IX_IEN);
  assign idis_we = wr_en && (idx == IX_IDIS);
  assign stat_rd = rd_en && (idx == IX_STAT);
  assign restart = wr_en && (idx == IX_CTRL) && (wdata[31:24] == RESTART_KEY) && wdata[0];

  always_comb begin
    period_d = period_q;
    rpth_d   = rpth_q;
    lvl_d    = lvl_q;
    m_prst_d = m_prst_q;
    m_rrst_d = m_rrst_q;
    m_dis_d  = m_dis_q;
    m_dbg_d  = m_dbg_q;
    m_idle_d = m_idle_q;
    if (win_we) begin
      period_d = wdata[CNT_W-1:0];
      rpth_d   = wdata[16 +: CNT_W];
    end
    if (lvl_we) lvl_d = wdata[CNT_W-1:0];
    if (mode_we) begin
      m_prst_d = wdata[MB_PRST];
      m_rrst_d = wdata[MB_RRST];
      m_dis_d  = wdata[MB_DIS];
      m_dbg_d  = wdata[MB_DBG];
      m_idle_d = wdata[MB_IDLE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '1;
      rpth_q   <= '1;
      lvl_q    <= '0;
      m_prst_q <= 1'b0;
      m_rrst_q <= 1'b0;
      m_dis_q  <= 1'b1;
      m_dbg_q  <= 1'b0;
      m_idle_q <= 1'b0;
    end else begin
      period_q <= period_d;
      rpth_q   <= rpth_d;
      lvl_q    <= lvl_d;
      m_prst_q <= m_prst_d;
      m_rrst_q <= m_rrst_d;
      m_dis_q  <= m_dis_d;
      m_dbg_q  <= m_dbg_d;
      m_idle_q <= m_idle_d;
    end
  end

  // counting path
  logic enabled, frozen, run, tick;
  logic [CNT_W-1:0] cnt;
  logic reload, rep_evt, per_evt, lvl_evt;

  assign enabled = !m_dis_q;
  assign frozen  = (dbg_halt && m_dbg_q) || (idle && m_idle_q);
  assign run     = enabled && !frozen;

  dtw_prescale #(.DIV(DIV)) u_psc (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick),
    .run(run), .clear(reload || !enabled), .tick(tick)
  );

  dtw_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart),
    .period(period_q), .rpth(rpth_q), .lvl(lvl_q), .cnt(cnt),
    .reload(reload), .rep_evt(rep_evt), .per_evt(per_evt), .lvl_evt(lvl_evt)
  );

  // interrupt registers
  logic [NIRQ-1:0] set_vec, status, mask;
  always_comb begin
    set_vec           = '0;
    set_vec[IB_PER]   = per_evt;
    set_vec[IB_REP]   = rep_evt;
    set_vec[IB_LVL]   = lvl_evt;
    set_vec[IB_PER_M] = per_evt;
    set_vec[IB_REP_M] = rep_evt;
  end

  dtw_irq #(.NIRQ(NIRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .stat_rd(stat_rd),
    .ien_we(ien_we), .idis_we(idis_we), .wbits(wdata[NIRQ-1:0]),
    .status(status), .mask(mask), .irq(irq)
  );

  // reset request pulse
  assign rst_req_d = (per_evt && m_prst_q) || (rep_evt && m_rrst_q);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_req_q <= 1'b0;
    else        rst_req_q <= rst_req_d;
  end
  assign rst_req = rst_req_q;

  // read mux
  always_comb begin
    rdata = '0;
    case (idx)
      IX_MODE: begin
        rdata[MB_PRST] = m_prst_q;
        rdata[MB_RRST] = m_rrst_q;
        rdata[MB_DIS]  = m_dis_q;
        rdata[MB_DBG]  = m_dbg_q;
        rdata[MB_IDLE] = m_idle_q;
      end
      IX_VAL:  rdata[CNT_W-1:0] = cnt;
      IX_WIN: begin
        rdata[CNT_W-1:0]  = period_q;
        rdata[16 +: CNT_W] = rpth_q;
      end
      IX_LVL:  rdata[CNT_W-1:0] = lvl_q;
      IX_STAT: rdata[NIRQ-1:0]  = status;
      IX_MASK: rdata[NIRQ-1:0]  = mask;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/dtw_checker.sv
module dtw_checker #(
  parameter int CNT_W = 12,
  parameter int NIRQ  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] period,
  input logic             reload,
  input logic             per_evt,
  input logic             rep_evt,
  input logic             m_prst,
  input logic             m_rrst,
  input logic             m_dis,
  input logic             m_dbg,
  input logic             dbg_halt,
  input logic             rst_req,
  input logic             stat_rd,
  input logic             ien_we,
  input logic [NIRQ-1:0]  wbits,
  input logic [NIRQ-1:0]  set_vec,
  input logic [NIRQ-1:0]  status,
  input logic [NIRQ-1:0]  mask
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reload |=> (cnt == $past(cnt)) || (cnt == $past(cnt) - ONE) ||
                ($past(cnt) == '0 && cnt == $past(period)));

  assert_per_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |=> status[0] && status[3]);

  assert_rst_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past((per_evt && m_prst) || (rep_evt && m_rrst)));

  assert_rep_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rep_evt |=> status[1] && status[4]);

  assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_dis && !reload) |=> $stable(cnt));

  assert_dbg_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && m_dbg && !reload) |=> $stable(cnt));

  assert_mask_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ien_we |=> ((mask & $past(wbits)) == $past(wbits)));

  assert_stat_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && set_vec == '0) |=> status == '0);
endmodule

bind dual_thresh_wdog dtw_checker #(.CNT_W(dtw_pkg::CNT_W), .NIRQ(dtw_pkg::NIRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .period(period_q), .reload(reload),
  .per_evt(per_evt), .rep_evt(rep_evt), .m_prst(m_prst_q), .m_rrst(m_rrst_q),
  .m_dis(m_dis_q), .m_dbg(m_dbg_q), .dbg_halt(dbg_halt), .rst_req(rst_req),
  .stat_rd(stat_rd), .ien_we(ien_we), .wbits(wdata[dtw_pkg::NIRQ-1:0]),
  .set_vec(set_vec), .status(status), .mask(mask)
);

// File: tb/dual_thresh_wdog_bench.sv
`timescale 1ns/1ps
module dual_thresh_wdog_bench;
  logic        clk, rst_n, slow_tick, dbg_halt, idle, wr_en, rd_en;
  logic [5:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq, rst_req;
  int total = 0, bad = 0;
  bit done = 0;

  dual_thresh_wdog u_dual_thresh_wdog (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .dbg_halt(dbg_halt),
    .idle(idle), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .rst_req(rst_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  localparam logic [5:0] A_CTRL = 6'h00, A_MODE = 6'h04, A_VAL = 6'h08,
    A_WIN = 6'h0C, A_LVL = 6'h10, A_IEN = 6'h14, A_IDIS = 6'h18,
    A_STAT = 6'h1C, A_MASK = 6'h20;
  localparam logic [31:0] GOOD = 32'hA500_0001;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1; #1 d = rdata;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic peek(input logic [5:0] a, output logic [31:0] d);
    addr = a; #1 d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic test_reset;
    logic [31:0] d;
    peek(A_VAL, d);  check("R1 value", d, 32'hFFF);
    peek(A_MODE, d); check("R1 mode", d, 32'h0000_1000);
    peek(A_MASK, d); check("R1 mask", d, 0);
    peek(A_STAT, d); check("R1 status", d, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 rst_req", {31'b0, rst_req}, 0);
  endtask

  task automatic test_ignored;
    logic [31:0] d;
    wr(A_VAL, 32'h0000_0123);
    peek(A_VAL, d);  check("R12 value write ignored", d, 32'hFFF);
    peek(6'h24, d);  check("R12 unmapped reads zero", d, 0);
    wait_cyc(300);
    peek(A_VAL, d);  check("R8 disabled holds", d, 32'hFFF);
  endtask

  task automatic test_restart_key;
    logic [31:0] d;
    wr(A_WIN, 32'h0FFF_0003);
    wr(A_LVL, 32'h0000_0002);
    wr(A_IEN, 32'h0000_0001);
    wr(A_CTRL, 32'h5A00_0001);
    peek(A_VAL, d); check("R3 wrong key ignored", d, 32'hFFF);
    wr(A_CTRL, 32'hA500_0000);
    peek(A_VAL, d); check("R3 missing bit0 ignored", d, 32'hFFF);
    wr(A_CTRL, GOOD);
    peek(A_VAL, d); check("R3 valid restart reloads", d, 32'h3);
  endtask

  task automatic test_period;
    logic [31:0] d;
    wr(A_MODE, 32'h0000_0010);
    wr(A_CTRL, GOOD);
    wait_cyc(128 * 3 - 1);
    peek(A_VAL, d); check("R2 count one step before zero", d, 32'h1);
    check("R4 irq not yet", {31'b0, irq}, 0);
    check("R5 no reset yet", {31'b0, rst_req}, 0);
    wait_cyc(1);
    peek(A_VAL, d); check("R2 count reaches zero", d, 32'h0);
    check("R4 irq on expiry", {31'b0, irq}, 1);
    check("R5 reset request", {31'b0, rst_req}, 1);
    wait_cyc(1);
    check("R5 reset pulse one cycle", {31'b0, rst_req}, 0);
    rd(A_STAT, d); check("R7 R4 status bits", d, 32'h0D);
    rd(A_STAT, d); check("R11 status cleared by read", d, 0);
    check("R10 irq low after clear", {31'b0, irq}, 0);
    for (int i = 0; i < 300; i++) begin
      peek(A_VAL, d);
      if (d != 0) break;
      wait_cyc(1);
    end
    check("R4 reload after zero", d, 32'h3);
  endtask

  task automatic test_repeat;
    logic [31:0] d;
    wr(A_MODE, 32'h0000_1030);
    rd(A_STAT, d);
    wr(A_WIN, 32'h0FFF_0003);
    wr(A_CTRL, GOOD);
    wr(A_WIN, 32'h0001_0003);
    wr(A_CTRL, GOOD);
    peek(A_VAL, d); check("R6 early restart no reload", d, 32'h3);
    check("R6 early restart reset", {31'b0, rst_req}, 1);
    rd(A_STAT, d); check("R6 status bits", d, 32'h12);
    wr(A_MODE, 32'h0000_1010);
    wr(A_CTRL, GOOD);
    check("R6 no reset without bit5", {31'b0, rst_req}, 0);
    peek(A_VAL, d); check("R6 count unchanged", d, 32'h3);
  endtask

  task automatic test_mask;
    logic [31:0] d;
    wr(A_IEN, 32'h0000_0002);
    rd(A_MASK, d); check("R10 mask set", d, 32'h3);
    check("R10 irq from repeat bit", {31'b0, irq}, 1);
    wr(A_IDIS, 32'h0000_0003);
    rd(A_MASK, d); check("R10 mask cleared", d, 0);
    check("R10 irq masked", {31'b0, irq}, 0);
    rd(A_STAT, d); check("R11 status held while masked", d, 32'h12);
    rd(A_STAT, d); check("R11 status cleared", d, 0);
  endtask

  task automatic test_freeze;
    logic [31:0] d;
    wr(A_MODE, 32'h0000_1000);
    wr(A_WIN, 32'h0FFF_0003);
    wr(A_CTRL, GOOD);
    dbg_halt = 1'b1;
    wr(A_MODE, 32'h1000_0000);
    wait_cyc(300);
    peek(A_VAL, d); check("R9 debug freeze", d, 32'h3);
    dbg_halt = 1'b0;
    wait_cyc(130);
    peek(A_VAL, d); check("R9 counts after debug release", d, 32'h2);
    wr(A_MODE, 32'h0000_1000);
    wr(A_CTRL, GOOD);
    idle = 1'b1;
    wr(A_MODE, 32'h2000_0000);
    wait_cyc(300);
    peek(A_VAL, d); check("R9 idle freeze", d, 32'h3);
    wr(A_MODE, 32'h0000_0000);
    wait_cyc(130);
    peek(A_VAL, d); check("R9 idle without bit29 counts", d, 32'h2);
    idle = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; slow_tick = 1'b1; dbg_halt = 1'b0; idle = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    test_reset;
    test_ignored;
    test_restart_key;
    test_period;
    test_repeat;
    test_mask;
    test_freeze;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule